// File: doc/BRIEF.md
# Headphone Control Register Target on a Two-Wire Serial Bus

This block is a bus target that lets a host processor set up a stereo headphone amplifier over a standard two-wire I2C bus. It runs on a fast system clock. It samples the serial clock and data lines through short synchronizers and finds START, repeated START and STOP conditions from the sampled levels. Through a byte pointer it reaches a small file of four 8-bit control registers. The register fields drive the amplifier directly: per-channel enables, a low-power standby, per-channel mutes, a 5-bit gain code and per-channel output tri-state.

A host writes by sending the write address, then a pointer byte, then one or more data bytes. Each data byte goes to the register the pointer names, and the pointer then advances by one. To read, the host sends the read address and takes bytes from wherever the pointer stands. The pointer is kept from one transaction to the next, so a read can follow a pointer set in an earlier transaction or come straight after a pointer set and a repeated START. A thermal-event input latches a status flag. The flag stays set until the host reads the register that holds it.

Top module: `hp_ctrl_i2c_target`

## Requirements
- R1: The target answers only the 7-bit address 1100000, with the direction bit 0 for write and 1 for read. It acknowledges a match by holding the data line low for the ninth clock. On any other address it never drives the line and ignores the bus until the next START or STOP.
- R2: In a write transaction the first byte after the address loads the pointer. Each later byte is stored at the pointer, after which the pointer advances by one. Every received byte is acknowledged.
- R3: In a read transaction the target sends the register at the pointer, MSB first, and the pointer advances by one for each byte sent. A master ACK (data low in the ninth clock) makes it send the next register. A master NACK ends the transfer.
- R4: The pointer keeps its value across STOP and START. A read with no pointer set returns the register at the retained pointer.
- R5: Register 0x01 holds left enable in bit 7, right enable in bit 6, the thermal flag in bit 1 and standby in bit 0. Reset values: standby 1, all other bits 0.
- R6: Register 0x02 holds left mute in bit 7 and right mute in bit 6, both resetting to 1. It holds the gain code in bits 5:1, resetting to 00000, and bit 0 reads 0.
- R7: Register 0x03 holds left tri-state in bit 1 and right tri-state in bit 0, both resetting to 0. Register 0x04 is read-only and reads 0x05: vendor code 00 in bits 7:6, bits 5:4 zero, revision 0101 in bits 3:0.
- R8: Reserved bits read 0. Writes to reserved bits, to read-only fields, or to pointer values outside 0x01..0x04 have no effect. A read outside that range returns 0x00.
- R9: A thermal event while standby is 0 sets the thermal flag. The flag holds until register 0x01 is loaded for transmission in a read. While standby is 1, events are ignored.
- R10: The target changes its data-line drive only while the sampled clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| therm_evt_i | input | 1 | Thermal event from the amplifier |
| amp_en_l | output | 1 | Left amplifier enable |
| amp_en_r | output | 1 | Right amplifier enable |
| standby | output | 1 | Low-power standby request |
| mute_l | output | 1 | Left channel mute |
| mute_r | output | 1 | Right channel mute |
| vol_code | output | 5 | Gain code |
| hiz_l | output | 1 | Left output tri-state |
| hiz_r | output | 1 | Right output tri-state |

## Verification
The bench builds the block with its defaults: two synchronizer stages, address 1100000 and revision 0101. With these, the target's acknowledge and read bits appear three system clocks after SCL falls, well inside a bus quarter-bit of six clocks. The bench can therefore sample every ninth-clock response at SCL high and check it against the wired-AND bus value. The same parameters let the bench expect fixed identity contents, and let it tell the retained pointer apart from the out-of-range reads that follow a four-register burst.

// File: rtl/hpc_pkg.sv
`timescale 1ns/1ps
package hpc_pkg;
   localparam int unsigned BYTE_W = 8;

   localparam logic [BYTE_W-1:0] RA_CTRL = 8'h01;
   localparam logic [BYTE_W-1:0] RA_GAIN = 8'h02;
   localparam logic [BYTE_W-1:0] RA_DRV  = 8'h03;
   localparam logic [BYTE_W-1:0] RA_IDEN = 8'h04;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACKW,
      ST_ACK,
      ST_TX,
      ST_MACK
   } link_state_e;

   typedef enum logic [1:0] {
      RB_ADDR,
      RB_PTR,
      RB_DATA
   } rx_role_e;
endpackage

// File: rtl/hpc_bus_sync.sv
`timescale 1ns/1ps
module hpc_bus_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   generate
      if (STAGES == 1) begin : g_single
         logic scl_ff, sda_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= 1'b1;
               sda_ff <= 1'b1;
            end else begin
               scl_ff <= scl_i;
               sda_ff <= sda_i;
            end
         end
         assign scl_lvl = scl_ff;
         assign sda_lvl = sda_ff;
      end else begin : g_chain
         logic [STAGES-1:0] scl_ff, sda_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[STAGES-2:0], scl_i};
               sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            end
         end
         assign scl_lvl = scl_ff[STAGES-1];
         assign sda_lvl = sda_ff[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_lvl;
         sda_q <= sda_lvl;
      end
   end

   assign scl_rise  = !scl_q && scl_lvl;
   assign scl_fall  = scl_q && !scl_lvl;
   assign start_det = scl_q && scl_lvl && sda_q && !sda_lvl;
   assign stop_det  = scl_q && scl_lvl && !sda_q && sda_lvl;
endmodule

// File: rtl/hpc_link.sv
`timescale 1ns/1ps
module hpc_link
   import hpc_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR  = 7'b1100000,
   parameter logic [BYTE_W-1:0] PTR_RESET = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] reg_ptr,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data,
   output logic              rd_take,
   output logic              sda_low
);
   link_state_e       state;
   rx_role_e          role;
   logic [2:0]        bitcnt;
   logic [6:0]        sreg;
   logic [BYTE_W-1:0] txreg;
   logic              rw;
   logic              mack;
   logic [BYTE_W-1:0] byte_in;
   logic              last_rx;

   always_comb begin
      byte_in = {sreg, sda_lvl};
      last_rx = (state == ST_RX) && scl_rise && (bitcnt == 3'd7);
      wr_en   = last_rx && (role == RB_DATA);
      wr_data = byte_in;
      rd_take = scl_fall &&
                (((state == ST_ACK) && (role == RB_ADDR) && rw) ||
                 ((state == ST_MACK) && mack));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         role    <= RB_ADDR;
         bitcnt  <= '0;
         sreg    <= '0;
         txreg   <= '0;
         rw      <= 1'b0;
         mack    <= 1'b0;
         reg_ptr <= PTR_RESET;
         sda_low <= 1'b0;
      end else if (start_det) begin
         state   <= ST_RX;
         role    <= RB_ADDR;
         bitcnt  <= '0;
         sda_low <= 1'b0;
      end else if (stop_det) begin
         state   <= ST_IDLE;
         sda_low <= 1'b0;
      end else begin
         case (state)
            ST_RX: begin
               if (scl_rise) begin
                  sreg   <= byte_in[6:0];
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     case (role)
                        RB_ADDR: begin
                           if (byte_in[7:1] == DEV_ADDR) begin
                              rw    <= byte_in[0];
                              state <= ST_ACKW;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        RB_PTR: begin
                           reg_ptr <= byte_in;
                           state   <= ST_ACKW;
                        end
                        default: begin
                           reg_ptr <= reg_ptr + 1'b1;
                           state   <= ST_ACKW;
                        end
                     endcase
                  end
               end
            end
            ST_ACKW: begin
               if (scl_fall) begin
                  sda_low <= 1'b1;
                  state   <= ST_ACK;
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if ((role == RB_ADDR) && rw) begin
                     txreg   <= rd_data;
                     reg_ptr <= reg_ptr + 1'b1;
                     sda_low <= ~rd_data[7];
                     state   <= ST_TX;
                  end else begin
                     sda_low <= 1'b0;
                     state   <= ST_RX;
                     role    <= (role == RB_ADDR) ? RB_PTR : RB_DATA;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     sda_low <= 1'b0;
                     state   <= ST_MACK;
                  end else begin
                     txreg   <= {txreg[6:0], 1'b0};
                     sda_low <= ~txreg[6];
                     bitcnt  <= bitcnt + 3'd1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  mack <= ~sda_lvl;
               end else if (scl_fall) begin
                  if (mack) begin
                     txreg   <= rd_data;
                     reg_ptr <= reg_ptr + 1'b1;
                     sda_low <= ~rd_data[7];
                     bitcnt  <= '0;
                     state   <= ST_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/hpc_regfile.sv
`timescale 1ns/1ps
module hpc_regfile
   import hpc_pkg::*;
#(
   parameter logic [3:0] REV_CODE    = 4'b0101,
   parameter logic [1:0] VENDOR_CODE = 2'b00,
   parameter int unsigned VOL_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] reg_ptr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_take,
   input  logic              therm_evt_i,
   output logic [BYTE_W-1:0] rd_data,
   output logic              therm_flag,
   output logic              amp_en_l,
   output logic              amp_en_r,
   output logic              standby,
   output logic              mute_l,
   output logic              mute_r,
   output logic [VOL_W-1:0]  vol_code,
   output logic              hiz_l,
   output logic              hiz_r
);
   logic therm_set, therm_clr;

   assign therm_set = therm_evt_i && !standby;
   assign therm_clr = rd_take && (reg_ptr == RA_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         amp_en_l <= 1'b0;
         amp_en_r <= 1'b0;
         standby  <= 1'b1;
         mute_l   <= 1'b1;
         mute_r   <= 1'b1;
         vol_code <= '0;
         hiz_l    <= 1'b0;
         hiz_r    <= 1'b0;
      end else if (wr_en) begin
         case (reg_ptr)
            RA_CTRL: begin
               amp_en_l <= wr_data[7];
               amp_en_r <= wr_data[6];
               standby  <= wr_data[0];
            end
            RA_GAIN: begin
               mute_l   <= wr_data[7];
               mute_r   <= wr_data[6];
               vol_code <= wr_data[VOL_W:1];
            end
            RA_DRV: begin
               hiz_l <= wr_data[1];
               hiz_r <= wr_data[0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         therm_flag <= 1'b0;
      else if (therm_set) therm_flag <= 1'b1;
      else if (therm_clr) therm_flag <= 1'b0;
   end

   always_comb begin
      case (reg_ptr)
         RA_CTRL: rd_data = {amp_en_l, amp_en_r, 4'b0000, therm_flag, standby};
         RA_GAIN: rd_data = {mute_l, mute_r, vol_code, 1'b0};
         RA_DRV:  rd_data = {6'b000000, hiz_l, hiz_r};
         RA_IDEN: rd_data = {VENDOR_CODE, 2'b00, REV_CODE};
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/hp_ctrl_i2c_target.sv
`timescale 1ns/1ps
module hp_ctrl_i2c_target #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR    = 7'b1100000,
   parameter logic [3:0]  REV_CODE    = 4'b0101,
   parameter logic [1:0]  VENDOR_CODE = 2'b00,
   parameter logic [7:0]  PTR_RESET   = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_drive_low,
   input  logic       therm_evt_i,
   output logic       amp_en_l,
   output logic       amp_en_r,
   output logic       standby,
   output logic       mute_l,
   output logic       mute_r,
   output logic [4:0] vol_code,
   output logic       hiz_l,
   output logic       hiz_r
);
   localparam int unsigned VOL_W = 5;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      initial $fatal(1, "SYNC_STAGES must lie in 1..4");
   end

   logic       scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
   logic [7:0] reg_ptr, rd_data, wr_data;
   logic       wr_en, rd_take, therm_flag;

   hpc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_lvl  (scl_sync),
      .sda_lvl  (sda_sync),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   hpc_link #(.DEV_ADDR(DEV_ADDR), .PTR_RESET(PTR_RESET)) u_link (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_lvl  (sda_sync),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .rd_data  (rd_data),
      .reg_ptr  (reg_ptr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_take  (rd_take),
      .sda_low  (sda_drive_low)
   );

   hpc_regfile #(.REV_CODE(REV_CODE), .VENDOR_CODE(VENDOR_CODE), .VOL_W(VOL_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_ptr    (reg_ptr),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_take    (rd_take),
      .therm_evt_i(therm_evt_i),
      .rd_data    (rd_data),
      .therm_flag (therm_flag),
      .amp_en_l   (amp_en_l),
      .amp_en_r   (amp_en_r),
      .standby    (standby),
      .mute_l     (mute_l),
      .mute_r     (mute_r),
      .vol_code   (vol_code),
      .hiz_l      (hiz_l),
      .hiz_r      (hiz_r)
   );
endmodule

// File: rtl/hpc_checker.sv
`timescale 1ns/1ps
module hpc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_sync,
   input logic       sda_drive_low,
   input logic       therm_evt_i,
   input logic       standby,
   input logic       therm_flag,
   input logic       rd_take,
   input logic       wr_en,
   input logic [7:0] reg_ptr,
   input logic [4:0] vol_code,
   input logic       hiz_l,
   input logic       hiz_r
);
   // R10: the drive is only asserted while the sampled clock is low
   a_r10_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> !scl_sync);

   // R9: the flag rises only from an event seen outside standby
   a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(therm_flag) |-> ($past(therm_evt_i) && !$past(standby)));

   // R9: the flag falls only when register 0x01 is taken for a read
   a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(therm_flag) |-> ($past(rd_take) && ($past(reg_ptr) == 8'h01)));

   // R2: each stored byte advances the pointer by one
   a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (reg_ptr == $past(reg_ptr) + 8'd1));

   // R6: the gain code moves only on a write to register 0x02
   a_r6_vol_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(vol_code) |-> ($past(wr_en) && ($past(reg_ptr) == 8'h02)));

   // R8: a write outside 0x01..0x04 leaves the tri-state fields alone
   a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (reg_ptr == 8'h00 || reg_ptr > 8'h04)) |=> ($stable(hiz_l) && $stable(hiz_r)));
endmodule

bind hp_ctrl_i2c_target hpc_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_sync     (scl_sync),
   .sda_drive_low(sda_drive_low),
   .therm_evt_i  (therm_evt_i),
   .standby      (standby),
   .therm_flag   (therm_flag),
   .rd_take      (rd_take),
   .wr_en        (wr_en),
   .reg_ptr      (reg_ptr),
   .vol_code     (vol_code),
   .hiz_l        (hiz_l),
   .hiz_r        (hiz_r)
);

// File: tb/hp_ctrl_i2c_target_test.sv
`timescale 1ns/1ps
module hp_ctrl_i2c_target_test;
   localparam int H = 6;
   localparam int NVEC = 8;
   // {pointer, written byte, expected read-back}
   localparam logic [23:0] VEC [NVEC] = '{
      24'h01FFC1, 24'h013E00, 24'h02FFFE, 24'h023636,
      24'h03FF03, 24'h03FC00, 24'h04FF05, 24'h07AA00
   };

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1, therm = 1'b0;
   logic sda_drive_low, amp_en_l, amp_en_r, standby, mute_l, mute_r, hiz_l, hiz_r;
   logic [4:0] vol_code;
   wire  sda_bus = m_sda & ~sda_drive_low;

   int n_cmp = 0, n_bad = 0;

   hp_ctrl_i2c_target uut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_drive_low(sda_drive_low), .therm_evt_i(therm),
      .amp_en_l(amp_en_l), .amp_en_r(amp_en_r), .standby(standby),
      .mute_l(mute_l), .mute_r(mute_r), .vol_code(vol_code),
      .hiz_l(hiz_l), .hiz_r(hiz_r)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_bit(input logic v, output logic s);
      m_sda = v;  tick(H);
      m_scl = 1'b1; tick(H);
      s = sda_bus; tick(H);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic b_start();
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic b_rstart();
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic b_stop();
      m_sda = 1'b0; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b1; tick(H);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         b[i] = s;
      end
      bus_bit(~give_ack, s);
   endtask

   task automatic write_reg(input logic [7:0] ptr, input logic [7:0] d);
      logic a;
      b_start();
      wr_byte(8'hC0, a); chk("R1 write address ack", {7'd0, a}, 8'h01);
      wr_byte(ptr, a);   chk("R2 pointer ack", {7'd0, a}, 8'h01);
      wr_byte(d, a);     chk("R2 data ack", {7'd0, a}, 8'h01);
      b_stop();
   endtask

   task automatic read_at(input logic [7:0] ptr, output logic [7:0] d);
      logic a;
      b_start();
      wr_byte(8'hC0, a);
      wr_byte(ptr, a);
      b_rstart();
      wr_byte(8'hC1, a); chk("R1 read address ack", {7'd0, a}, 8'h01);
      rd_byte(1'b0, d);
      b_stop();
   endtask

   task automatic read_here(output logic [7:0] d);
      logic a;
      b_start();
      wr_byte(8'hC1, a);
      rd_byte(1'b0, d);
      b_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic a;
      tick(10);
      rst_n = 1'b1;
      tick(10);

      // reset state at the ports
      chk("R5 reset enables/standby", {5'd0, amp_en_l, amp_en_r, standby}, 8'h01);
      chk("R6 reset mutes", {6'd0, mute_l, mute_r}, 8'h03);
      chk("R6 reset gain", {3'd0, vol_code}, 8'h00);
      chk("R7 reset tri-state", {6'd0, hiz_l, hiz_r}, 8'h00);
      chk("R10 idle drive", {7'd0, sda_drive_low}, 8'h00);

      // R3 burst read of all four registers from pointer 0x01
      b_start();
      wr_byte(8'hC0, a); chk("R1 address ack", {7'd0, a}, 8'h01);
      wr_byte(8'h01, a); chk("R2 pointer ack", {7'd0, a}, 8'h01);
      b_rstart();
      wr_byte(8'hC1, a); chk("R1 read address ack", {7'd0, a}, 8'h01);
      rd_byte(1'b1, d); chk("R5 reset reg 0x01", d, 8'h01);
      rd_byte(1'b1, d); chk("R6 reset reg 0x02", d, 8'hC0);
      rd_byte(1'b1, d); chk("R7 reset reg 0x03", d, 8'h00);
      rd_byte(1'b0, d); chk("R7 identity reg 0x04", d, 8'h05);
      b_stop();

      // R4 pointer retained after the burst: now at 0x05, out of range
      read_here(d); chk("R4 R8 retained pointer 0x05", d, 8'h00);
      read_at(8'h02, d); chk("R3 read 0x02", d, 8'hC0);
      read_here(d); chk("R4 retained pointer 0x03", d, 8'h00);
      read_here(d); chk("R4 retained pointer 0x04", d, 8'h05);

      // table of write/read-back vectors
      for (int i = 0; i < NVEC; i++) begin
         write_reg(VEC[i][23:16], VEC[i][15:8]);
         read_at(VEC[i][23:16], d);
         chk("R8 write/read-back vector", d, VEC[i][7:0]);
      end
      chk("R6 gain code from 0x36", {3'd0, vol_code}, 8'h1B);
      chk("R5 standby cleared", {5'd0, amp_en_l, amp_en_r, standby}, 8'h00);

      // R2 multi-byte write with auto-increment
      b_start();
      wr_byte(8'hC0, a);
      wr_byte(8'h01, a);
      wr_byte(8'h80, a); chk("R2 burst byte 1 ack", {7'd0, a}, 8'h01);
      wr_byte(8'h7E, a); chk("R2 burst byte 2 ack", {7'd0, a}, 8'h01);
      wr_byte(8'h02, a); chk("R2 burst byte 3 ack", {7'd0, a}, 8'h01);
      b_stop();
      chk("R2 R5 ports after burst", {5'd0, amp_en_l, amp_en_r, standby}, 8'h04);
      chk("R2 R6 mutes after burst", {6'd0, mute_l, mute_r}, 8'h01);
      chk("R2 R6 gain after burst", {3'd0, vol_code}, 8'h1F);
      chk("R2 R7 tri-state after burst", {6'd0, hiz_l, hiz_r}, 8'h02);

      // R1 wrong address: no ack, traffic ignored
      b_start();
      wr_byte(8'hC2, a); chk("R1 foreign address nack", {7'd0, a}, 8'h00);
      wr_byte(8'h03, a); chk("R1 ignored byte nack", {7'd0, a}, 8'h00);
      wr_byte(8'h00, a);
      b_stop();
      chk("R1 tri-state untouched", {6'd0, hiz_l, hiz_r}, 8'h02);
      b_start();
      wr_byte(8'hC3, a); chk("R1 foreign read nack", {7'd0, a}, 8'h00);
      rd_byte(1'b0, d); chk("R1 foreign read no drive", d, 8'hFF);
      b_stop();

      // R9 thermal flag: set outside standby, cleared by the read
      therm = 1'b1; tick(1); therm = 1'b0; tick(2);
      read_at(8'h01, d); chk("R9 flag set", d, 8'h82);
      read_at(8'h01, d); chk("R9 flag cleared by read", d, 8'h80);
      write_reg(8'h01, 8'h81);
      therm = 1'b1; tick(1); therm = 1'b0; tick(2);
      read_at(8'h01, d); chk("R9 event ignored in standby", d, 8'h81);
      chk("R10 drive released at end", {7'd0, sda_drive_low}, 8'h00);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule